// File: doc/BRIEF.md
# Power-Up Write Recovery and Default Loader

This block guards a register-based device around supply return. While the supply-good input is low the device is deselected and no write is accepted. When supply-good is seen high, the block loads the control bits with their power-up values and then keeps the device deselected for a recovery interval, counted on the block clock. Only after that interval does it raise the chip-enable-allowed output and accept writes again.

Two power-up kinds are told apart by the first-power input, which is sampled on the edge where supply-good is first seen high. A first power-up (battery newly attached) forces every control bit to a fixed value. A later power-up with battery backup keeps some bits, so software choices survive. The recovery interval has three nominal lengths. A recovery-select bit picks the short one. When that bit is clear, a stop bit picks between the long default length and a slightly shorter fixed length.

Top module: `pwrup_guard`

## Requirements
- R1: While reset is held and on its release, chipEnOk is 0 and every address reads 0x00.
- R2: When supplyGood is low at a rising edge, chipEnOk is 0 after that edge, whatever the state.
- R3: With recovery-select = 1, chipEnOk rises just after edge E0+FAST_CYC, where E0 is the edge at which supplyGood is first sampled high. The stop bit has no effect in this case.
- R4: With recovery-select = 0 and stop = 1, chipEnOk rises just after edge E0+DFLT_CYC.
- R5: With recovery-select = 0 and stop = 0, chipEnOk rises just after edge E0+SLOW_CYC.
- R6: The recovery-select bit is bit 7 of address 0x4. The other bits of that address read 0.
- R7: On a power-up with firstPower = 1, the block sets stop, out and halt to 1. It clears recovery-select, freq-test, alarm-flag-enable, alarm-battery-enable, square-wave-enable and the watchdog byte. Reads then give 0x1 = 0xC0, 0x2 = 0x10, 0x3 = 0x00 and 0x4 = 0x00.
- R8: On a power-up with firstPower = 0, the block keeps recovery-select, stop and out unchanged and sets halt to 1. It clears freq-test, the three enables and the watchdog byte.
- R9: A write strobe while chipEnOk is 0 (supply low or recovering) changes no register.
- R10: If supplyGood falls during recovery, the interval is abandoned. The next rise counts a full interval again from zero.
- R11: Register map. Address 0x1 holds stop at bit 7, out at bit 6 and freq-test at bit 5. Address 0x2 holds alarm-flag-enable at bit 7, alarm-battery-enable at bit 6, square-wave-enable at bit 5 and halt at bit 4. Address 0x3 is the 8-bit watchdog byte. Unlisted bits and addresses read 0 and ignore writes. A write takes effect at the rising edge where wrEn = 1 and chipEnOk = 1. rdData shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock for the recovery counter |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyGood | input | 1 | Supply above the power-fail threshold |
| firstPower | input | 1 | 1 = battery newly attached, sampled at supply rise |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Addressed register contents |
| chipEnOk | output | 1 | Device may be selected and written |

## Verification
The hardest case to reach is a supply drop in the middle of a recovery interval, combined with a write strobe issued inside that same interval. The bench gets there by raising supplyGood, waiting a few cycles, issuing a write and then dropping supplyGood. It then raises supplyGood again and times the whole fresh interval. A behavioural model follows the state and counter every cycle. Directed steps set the stop and recovery-select bits through the write port so that every interval length is reached on both kinds of power-up.

// File: rtl/pwrup_guard_pkg.sv
package pwrup_guard_pkg;

  typedef enum logic [1:0] {
    PG_OFF     = 2'd0,
    PG_RECOVER = 2'd1,
    PG_READY   = 2'd2
  } pgState_e;

  typedef enum logic [1:0] {
    POL_CLR  = 2'd0,
    POL_SET  = 2'd1,
    POL_KEEP = 2'd2
  } rstPol_e;

  // control -> datapath strobes
  typedef struct packed {
    logic loadInit;
    logic loadWarm;
    logic wrAllow;
  } pgStrobe_t;

  localparam int NUM_FLAGS = 8;
  localparam int F_STOP    = 0;
  localparam int F_OUT     = 1;
  localparam int F_FT      = 2;
  localparam int F_AFE     = 3;
  localparam int F_ABE     = 4;
  localparam int F_SQWE    = 5;
  localparam int F_HT      = 6;
  localparam int F_RECSEL  = 7;

  localparam int WDOG_ADDR = 3;

  // location of every single-bit flag
  localparam int FLAG_ADDR [NUM_FLAGS] = '{1, 1, 1, 2, 2, 2, 2, 4};
  localparam int FLAG_BIT  [NUM_FLAGS] = '{7, 6, 5, 7, 6, 5, 4, 7};

  // value taken on each kind of power-up
  localparam rstPol_e INIT_POL [NUM_FLAGS] =
    '{POL_SET, POL_SET, POL_CLR, POL_CLR, POL_CLR, POL_CLR, POL_SET, POL_CLR};
  localparam rstPol_e WARM_POL [NUM_FLAGS] =
    '{POL_KEEP, POL_KEEP, POL_CLR, POL_CLR, POL_CLR, POL_CLR, POL_SET, POL_KEEP};

  function automatic logic applyPol(input rstPol_e pol, input logic cur);
    case (pol)
      POL_CLR: applyPol = 1'b0;
      POL_SET: applyPol = 1'b1;
      default: applyPol = cur;
    endcase
  endfunction

endpackage

// File: rtl/pwrup_guard_timer.sv
module pwrup_guard_timer #(
  parameter int SLOW_CYC = 3178,
  parameter int DFLT_CYC = 3932,
  parameter int FAST_CYC = 33
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  input  logic recSel,
  input  logic stopBit,
  output logic done
);

  localparam int MAX_CYC = (SLOW_CYC > DFLT_CYC) ?
                           ((SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC) :
                           ((DFLT_CYC > FAST_CYC) ? DFLT_CYC : FAST_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  always_comb begin
    if (recSel)       limit = CNT_W'(FAST_CYC);
    else if (stopBit) limit = CNT_W'(DFLT_CYC);
    else              limit = CNT_W'(SLOW_CYC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     cnt <= '0;
    else if (!run) cnt <= '0;
    else           cnt <= cnt + CNT_W'(1);
  end

  assign done = run && (cnt == limit - CNT_W'(1));

  assert_count_below_limit_R5: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (cnt < limit));

  assert_restart_from_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (cnt == '0));

endmodule

// File: rtl/pwrup_guard_regs.sv
module pwrup_guard_regs
  import pwrup_guard_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgStrobe_t         strobe,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              recSel,
  output logic              stopBit
);

  logic [NUM_FLAGS-1:0] flagQ;
  logic [DATA_W-1:0]    wdogQ;
  logic                 wrOk;

  assign wrOk = strobe.wrAllow && wrEn;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        flagQ[i] <= 1'b0;
      else if (strobe.loadInit)
        flagQ[i] <= applyPol(INIT_POL[i], flagQ[i]);
      else if (strobe.loadWarm)
        flagQ[i] <= applyPol(WARM_POL[i], flagQ[i]);
      else if (wrOk && (wrAddr == ADDR_W'(FLAG_ADDR[i])))
        flagQ[i] <= wrData[FLAG_BIT[i]];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      wdogQ <= '0;
    else if (strobe.loadInit || strobe.loadWarm)
      wdogQ <= '0;
    else if (wrOk && (wrAddr == ADDR_W'(WDOG_ADDR)))
      wdogQ <= wrData;
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(WDOG_ADDR)) rdData = wdogQ;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      if (rdAddr == ADDR_W'(FLAG_ADDR[i])) rdData[FLAG_BIT[i]] = flagQ[i];
    end
  end

  assign recSel  = flagQ[F_RECSEL];
  assign stopBit = flagQ[F_STOP];

  assert_quiet_when_blocked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wrAllow && !strobe.loadInit && !strobe.loadWarm) |=> $stable({flagQ, wdogQ}));

  assert_initial_defaults_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadInit |=> (flagQ[F_STOP] && flagQ[F_OUT] && flagQ[F_HT] &&
                         !flagQ[F_RECSEL] && (wdogQ == '0)));

  assert_warm_keeps_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadWarm |=> ((flagQ[F_RECSEL] == $past(flagQ[F_RECSEL])) &&
                         (flagQ[F_STOP] == $past(flagQ[F_STOP])) &&
                         flagQ[F_HT] && (wdogQ == '0)));

endmodule

// File: rtl/pwrup_guard_ctrl.sv
module pwrup_guard_ctrl
  import pwrup_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      supplyGood,
  input  logic      firstPower,
  input  logic      timerDone,
  output logic      timerRun,
  output pgStrobe_t strobe,
  output logic      chipEnOk
);

  pgState_e state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      state <= PG_OFF;
    else if (!supplyGood)
      state <= PG_OFF;
    else begin
      case (state)
        PG_OFF:     state <= PG_RECOVER;
        PG_RECOVER: if (timerDone) state <= PG_READY;
        PG_READY:   state <= PG_READY;
        default:    state <= PG_OFF;
      endcase
    end
  end

  always_comb begin
    strobe.loadInit = (state == PG_OFF) && supplyGood && firstPower;
    strobe.loadWarm = (state == PG_OFF) && supplyGood && !firstPower;
    strobe.wrAllow  = (state == PG_READY);
  end

  assign timerRun = (state == PG_RECOVER);
  assign chipEnOk = (state == PG_READY);

  assert_drop_on_supply_loss_R2: assert property (@(posedge clk) disable iff (!rstN)
    !supplyGood |=> !chipEnOk);

  assert_ready_after_timer_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chipEnOk) |-> $past(timerDone));

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadInit, strobe.loadWarm, strobe.wrAllow}));

endmodule

// File: rtl/pwrup_guard.sv
module pwrup_guard
  import pwrup_guard_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int SLOW_CYC = 3178,
  parameter int DFLT_CYC = 3932,
  parameter int FAST_CYC = 33
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyGood,
  input  logic              firstPower,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              chipEnOk
);

  pgStrobe_t strobe;
  logic      timerRun;
  logic      timerDone;
  logic      recSel;
  logic      stopBit;

  pwrup_guard_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .supplyGood (supplyGood),
    .firstPower (firstPower),
    .timerDone  (timerDone),
    .timerRun   (timerRun),
    .strobe     (strobe),
    .chipEnOk   (chipEnOk)
  );

  pwrup_guard_timer #(
    .SLOW_CYC (SLOW_CYC),
    .DFLT_CYC (DFLT_CYC),
    .FAST_CYC (FAST_CYC)
  ) u_timer (
    .clk     (clk),
    .rstN    (rstN),
    .run     (timerRun),
    .recSel  (recSel),
    .stopBit (stopBit),
    .done    (timerDone)
  );

  pwrup_guard_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .recSel  (recSel),
    .stopBit (stopBit)
  );

endmodule

// File: tb/pwrup_guard_bench.sv
module pwrup_guard_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SLOW = 40;
  localparam int DFLT = 60;
  localparam int FAST = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       supplyGood = 1'b0;
  logic       firstPower = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       chipEnOk;

  int nCheck = 0;
  int nBad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrup_guard #(
    .ADDR_W(3), .DATA_W(8), .SLOW_CYC(SLOW), .DFLT_CYC(DFLT), .FAST_CYC(FAST)
  ) u_pwrup_guard (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .firstPower(firstPower),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .chipEnOk(chipEnOk)
  );

  // ---------------- behavioural reference ----------------
  int mState = 0;  // 0 off, 1 recovering, 2 ready
  int mCnt = 0;
  bit mStop, mOut, mFt, mAfe, mAbe, mSqwe, mHt, mRs;
  bit [7:0] mWd;

  function automatic logic [7:0] mRead(input logic [2:0] a);
    case (a)
      3'd1: mRead = {mStop, mOut, mFt, 5'b0};
      3'd2: mRead = {mAfe, mAbe, mSqwe, mHt, 4'b0};
      3'd3: mRead = mWd;
      3'd4: mRead = {mRs, 7'b0};
      default: mRead = 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    int lim;
    if (!rstN) begin
      mState = 0; mCnt = 0; mWd = 0;
      {mStop, mOut, mFt, mAfe, mAbe, mSqwe, mHt, mRs} = '0;
    end else begin
      if (mState == 2 && wrEn) begin
        case (wrAddr)
          3'd1: {mStop, mOut, mFt} = wrData[7:5];
          3'd2: {mAfe, mAbe, mSqwe, mHt} = wrData[7:4];
          3'd3: mWd = wrData;
          3'd4: mRs = wrData[7];
          default: ;
        endcase
      end
      lim = mRs ? FAST : (mStop ? DFLT : SLOW);
      if (!supplyGood) begin
        mState = 0; mCnt = 0;
      end else if (mState == 0) begin
        if (firstPower) begin
          mStop = 1; mOut = 1; mRs = 0;
        end
        mHt = 1; mFt = 0; mAfe = 0; mAbe = 0; mSqwe = 0; mWd = 0;
        mState = 1; mCnt = 0;
      end else if (mState == 1) begin
        if (mCnt == lim - 1) mState = 2;
        else mCnt++;
      end
    end
  end

  always @(negedge clk) begin
    #3;
    if (rstN) begin
      nCheck++;
      if (chipEnOk !== (mState == 2)) begin
        nBad++;
        $display("FAIL R2/R3/R4/R5/R10 chipEnOk actual=%0b expected=%0b", chipEnOk, mState == 2);
      end
      nCheck++;
      if (rdData !== mRead(rdAddr)) begin
        nBad++;
        $display("FAIL R7/R8/R9/R11 rdData@%0d actual=%02h expected=%02h",
                 rdAddr, rdData, mRead(rdAddr));
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nCheck++; nBad++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", nCheck, nBad);
      $finish;
    end
  end

  // ---------------- directed steps ----------------
  task automatic check(input string tag, input int act, input int exp);
    nCheck++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    rdAddr = a;
    #1 v = rdData;
  endtask

  task automatic expectReg(input string tag, input logic [2:0] a, input logic [7:0] e);
    logic [7:0] v;
    readReg(a, v);
    check(tag, v, e);
  endtask

  task automatic powerUp(input string tag, input logic first, input int n);
    int edges = 0;
    @(negedge clk);
    firstPower = first; supplyGood = 1'b1;
    while (edges < 100000) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (chipEnOk) break;
    end
    check(tag, edges, n + 1);
  endtask

  task automatic powerDown();
    @(negedge clk);
    supplyGood = 1'b0;
    @(negedge clk);
    check("R2 chipEnOk after supply loss", chipEnOk, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 chipEnOk in reset", chipEnOk, 0);
    rstN = 1'b1;
    for (int a = 0; a < 8; a++) expectReg("R1 reset readback", 3'(a), 8'h00);

    // first power-up: default stop=1, recSel=0
    powerUp("R4 first power-up interval", 1'b1, DFLT);
    expectReg("R7 addr1", 3'd1, 8'hC0);
    expectReg("R7 addr2", 3'd2, 8'h10);
    expectReg("R7 addr3", 3'd3, 8'h00);
    expectReg("R7 addr4", 3'd4, 8'h00);

    writeReg(3'd1, 8'h3F);
    expectReg("R11 addr1 masked", 3'd1, 8'h20);
    writeReg(3'd2, 8'hEF);
    expectReg("R11 addr2 masked", 3'd2, 8'hE0);
    writeReg(3'd3, 8'h5A);
    expectReg("R11 watchdog byte", 3'd3, 8'h5A);
    writeReg(3'd4, 8'hFF);
    expectReg("R6 recSel bit7 only", 3'd4, 8'h80);
    writeReg(3'd5, 8'hFF);
    expectReg("R11 unmapped addr", 3'd5, 8'h00);
    writeReg(3'd4, 8'h00);

    powerDown();
    writeReg(3'd3, 8'hFF);
    expectReg("R9 write while off", 3'd3, 8'h5A);

    // warm: stop=0 recSel=0 kept
    powerUp("R5 slow interval", 1'b0, SLOW);
    expectReg("R8 addr1 kept", 3'd1, 8'h00);
    expectReg("R8 addr2 halt set", 3'd2, 8'h10);
    expectReg("R8 watchdog cleared", 3'd3, 8'h00);

    // abort in mid-recovery with a write attempt
    powerDown();
    @(negedge clk);
    supplyGood = 1'b1; firstPower = 1'b0;
    repeat (5) @(negedge clk);
    writeReg(3'd3, 8'h77);
    supplyGood = 1'b0;
    repeat (2) @(negedge clk);
    expectReg("R9 write while recovering", 3'd3, 8'h00);
    powerUp("R10 restart full interval", 1'b0, SLOW);

    // fast selection, stop=1
    writeReg(3'd4, 8'h80);
    writeReg(3'd1, 8'hC0);
    powerDown();
    powerUp("R3 fast interval stop=1", 1'b0, FAST);
    expectReg("R8 recSel kept", 3'd4, 8'h80);
    expectReg("R8 stop/out kept", 3'd1, 8'hC0);

    // fast selection, stop=0
    writeReg(3'd1, 8'h00);
    powerDown();
    powerUp("R3 fast interval stop=0", 1'b0, FAST);

    // warm with stop=1 recSel=0
    writeReg(3'd1, 8'h80);
    writeReg(3'd4, 8'h00);
    powerDown();
    powerUp("R4 warm default interval", 1'b0, DFLT);

    // initial power-up clears recSel
    writeReg(3'd4, 8'h80);
    writeReg(3'd1, 8'h00);
    powerDown();
    powerUp("R7 initial clears recSel", 1'b1, DFLT);
    expectReg("R7 recSel cleared", 3'd4, 8'h00);
    expectReg("R7 stop/out set", 3'd1, 8'hC0);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", nCheck, nBad);
    $finish;
  end

endmodule